// File: doc/BRIEF.md
# Multiword Arithmetic Launch and Result-Stall Controller

This block is the host-side control unit of a multiword arithmetic coprocessor. Software writes operand pointers, operand lengths, a shift count and a function word through a small write port. A function write with the run bit set and exactly one operation bit launches a basic operation. The arithmetic datapath sits outside this block. It receives a one-cycle launch pulse and, when it finishes, returns a done pulse carrying the compare flags, the result most-significant-word value and the remainder most-significant-word value.

While an operation runs, the active operand registers stay frozen, so the datapath always sees stable values. Writes to pointer or length registers during that time go into a shadow copy. The shadow copy moves to the active register when the run bit drops. Writes to the operation bits and to the shift count are dropped while the operation runs.

A stall-result bit lets software keep reading the previous results after starting a short operation. With stall set, a finished operation leaves the run bit high and leaves the result registers unchanged. The result is published one cycle after software clears the stall bit. The interrupt output is the inverse of the run bit.

Top module: `bignum_op_ctl`

## Requirements
- R1: After a synchronous active-low reset, run, stall_res, op_start, all pointer, length, shift, op-select and result outputs are 0, and irq is 1.
- R2: Register select codes are 0..3 for pointers A..D, 4 and 5 for lengths A and B, 6 for the shift count and 7 for the function word. Pointers keep wr_data[10:1] with bit 0 forced to 0. Lengths keep wr_data[8:0]. The shift count keeps wr_data[4:0].
- R3: While run is 0, a register write is visible on its output in the cycle after the write edge.
- R4: While run is 1, pointer and length outputs do not change. A write to one of them is held in a shadow copy and appears on the output when run falls. Registers not written during the run keep their values.
- R5: A function write with run is 0 and with bit 15 set and exactly one operation bit among bits 0, 1 and 4..11 sets run to 1, raises op_start for exactly one cycle, and loads op_sel with wr_data[11:0]. Bit 3 (most-significant-one modifier) is not an operation bit.
- R6: A function write with bit 15 set but zero or several operation bits leaves run at 0 and gives no op_start.
- R7: While run is 1, writes to op_sel (function bits [11:0]) and to the shift count have no effect.
- R8: A dp_done pulse while run is 1 with stall_res at 0 clears run, sets irq, and loads cmp_res, msw_res and divmsw_res from the datapath, all on the same edge.
- R9: Function bit 24 sets stall_res and may be written at any time. If dp_done arrives while stall_res is 1, run stays 1 and the result outputs hold. One cycle after a write that clears bit 24, run clears and the held results appear.
- R10: cmp_res uses bit 2 for A greater than B, bit 1 for A less than B and bit 0 for A equal to B.
- R11: A start request written while a stalled result is pending is discarded, and op_sel keeps its value.
- R12: dp_done while run is 0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 32 | Write data |
| dp_done | input | 1 | Datapath completion pulse |
| dp_cmp | input | 3 | Compare flags from datapath |
| dp_msw | input | 16 | Result MSW info from datapath |
| dp_divmsw | input | 16 | Remainder MSW info from datapath |
| ptr_a | output | 11 | Active pointer A |
| ptr_b | output | 11 | Active pointer B |
| ptr_c | output | 11 | Active pointer C |
| ptr_d | output | 11 | Active pointer D |
| len_a | output | 9 | Active length A in words |
| len_b | output | 9 | Active length B in words |
| shift_cnt | output | 5 | Shift count |
| op_sel | output | 12 | Function bits [11:0] |
| run | output | 1 | Operation in progress |
| stall_res | output | 1 | Result stall enable |
| op_start | output | 1 | One-cycle launch pulse to datapath |
| cmp_res | output | 3 | Published compare flags |
| msw_res | output | 16 | Published result MSW info |
| divmsw_res | output | 16 | Published remainder MSW info |
| irq | output | 1 | Completion interrupt, inverse of run |

## Verification
Every write, the launch and the direct publication land on the edge that samples them, so their effect is due one cycle after the stimulus. A stalled result is due one cycle after the write that clears stall, which is two edges after that write starts. The bench drives on the falling edge and holds each stimulus for one full cycle. It samples at the next falling edge, and for a stall release it samples at the falling edge after that. It sweeps every pointer and length value and all 4096 op-select patterns with the run bit set, and it derives the expected start decision and compare flags arithmetically.

// File: rtl/bn_ctl_pkg.sv
// Shared constants and helpers for the multiword launch controller.
// Assumes a 32-bit host write port and a fixed function-word layout.
package bn_ctl_pkg;
    localparam int WDATA_W   = 32;
    localparam int SEL_W     = 3;
    localparam int OPS_W     = 12;
    localparam int RUN_BIT   = 15;
    localparam int STALL_BIT = 24;

    typedef enum logic [SEL_W-1:0] {
        SEL_PTR_A = 3'd0,
        SEL_PTR_B = 3'd1,
        SEL_PTR_C = 3'd2,
        SEL_PTR_D = 3'd3,
        SEL_LEN_A = 3'd4,
        SEL_LEN_B = 3'd5,
        SEL_SHIFT = 3'd6,
        SEL_FUNC  = 3'd7
    } reg_sel_e;

    // True when exactly one operation bit (0, 1, 4..11) is set; bit 3 is a modifier.
    function automatic logic single_op(input logic [OPS_W-1:0] f);
        return $countones({f[11:4], f[1:0]}) == 1;
    endfunction
endpackage

// File: rtl/bn_shadow_reg.sv
// Operand register with a shadow copy.
// Writes while idle go straight to the active value. Writes while busy go to the
// shadow and are committed when the operation publishes its result.
// Assumes commit is only asserted while busy is high.
module bn_shadow_reg #(
    parameter int W      = 11,
    parameter bit ALIGN0 = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         busy,
    input  logic         commit,
    output logic [W-1:0] value
);
    logic [W-1:0] act_q, shd_q, wv;
    logic         pend_q;

    // Apply the alignment rule to incoming data.
    always_comb begin
        wv = wdata;
        if (ALIGN0) wv[0] = 1'b0;
    end

    // Active/shadow update: a commit wins, and a same-cycle write is taken directly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            shd_q  <= '0;
            pend_q <= 1'b0;
        end else if (commit) begin
            act_q  <= wr ? wv : (pend_q ? shd_q : act_q);
            pend_q <= 1'b0;
        end else if (wr && busy) begin
            shd_q  <= wv;
            pend_q <= 1'b1;
        end else if (wr) begin
            act_q  <= wv;
            pend_q <= 1'b0;
        end
    end

    assign value = act_q;
endmodule

// File: rtl/bn_func_ctrl.sv
// Function word, shift count, run flag and stall handling.
// Launches an operation on a valid single-operation start and tracks completion.
// Produces publish strobes for the result store and the operand shadows.
// Assumes dp_done is a single-cycle pulse from the datapath.
module bn_func_ctrl
    import bn_ctl_pkg::*;
#(
    parameter int SHF_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_func,
    input  logic               wr_shift,
    input  logic [WDATA_W-1:0] wr_data,
    input  logic               dp_done,
    output logic               run,
    output logic               stall,
    output logic [OPS_W-1:0]   op_sel,
    output logic [SHF_W-1:0]   shift_cnt,
    output logic               op_start,
    output logic               hold_en,
    output logic               pub_direct,
    output logic               pub_release
);
    logic             run_q, stall_q, pend_q, start_q;
    logic [OPS_W-1:0] op_q;
    logic [SHF_W-1:0] shf_q;
    logic             done_acc;

    // Completion decode: accept done only for a live, unpublished operation.
    always_comb begin
        done_acc    = dp_done && run_q && !pend_q;
        pub_direct  = done_acc && !stall_q;
        hold_en     = done_acc && stall_q;
        pub_release = pend_q && !stall_q;
    end

    // Function word, run flag, launch pulse and pending-result state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            stall_q <= 1'b0;
            pend_q  <= 1'b0;
            start_q <= 1'b0;
            op_q    <= '0;
        end else begin
            start_q <= 1'b0;
            if (wr_func) begin
                stall_q <= wr_data[STALL_BIT];
                if (!run_q) begin
                    op_q <= wr_data[OPS_W-1:0];
                    if (wr_data[RUN_BIT] && single_op(wr_data[OPS_W-1:0])) begin
                        run_q   <= 1'b1;
                        start_q <= 1'b1;
                    end
                end
            end
            if (pub_direct || pub_release) run_q <= 1'b0;
            if (hold_en)          pend_q <= 1'b1;
            else if (pub_release) pend_q <= 1'b0;
        end
    end

    // Shift count, frozen while an operation runs.
    always_ff @(posedge clk) begin
        if (!rst_n)                  shf_q <= '0;
        else if (wr_shift && !run_q) shf_q <= wr_data[SHF_W-1:0];
    end

    assign run       = run_q;
    assign stall     = stall_q;
    assign op_sel    = op_q;
    assign shift_cnt = shf_q;
    assign op_start  = start_q;
endmodule

// File: rtl/bn_result_hold.sv
// Result status store: compare flags, result MSW info and remainder MSW info.
// Loads directly on an unstalled completion, or parks values and loads them on release.
// Assumes hold_en, pub_direct and pub_release are mutually exclusive.
module bn_result_hold #(
    parameter int CMP_W = 3,
    parameter int MSW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_en,
    input  logic             pub_direct,
    input  logic             pub_release,
    input  logic [CMP_W-1:0] dp_cmp,
    input  logic [MSW_W-1:0] dp_msw,
    input  logic [MSW_W-1:0] dp_divmsw,
    output logic [CMP_W-1:0] cmp_res,
    output logic [MSW_W-1:0] msw_res,
    output logic [MSW_W-1:0] divmsw_res
);
    logic [CMP_W-1:0] cmp_h, cmp_q;
    logic [MSW_W-1:0] msw_h, msw_q, div_h, div_q;

    // Park values delivered during a stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_h <= '0; msw_h <= '0; div_h <= '0;
        end else if (hold_en) begin
            cmp_h <= dp_cmp; msw_h <= dp_msw; div_h <= dp_divmsw;
        end
    end

    // Visible result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0; msw_q <= '0; div_q <= '0;
        end else if (pub_direct) begin
            cmp_q <= dp_cmp; msw_q <= dp_msw; div_q <= dp_divmsw;
        end else if (pub_release) begin
            cmp_q <= cmp_h; msw_q <= msw_h; div_q <= div_h;
        end
    end

    assign cmp_res    = cmp_q;
    assign msw_res    = msw_q;
    assign divmsw_res = div_q;
endmodule

// File: rtl/bignum_op_ctl.sv
// Top: host control for a multiword arithmetic coprocessor.
// Holds four aligned operand pointers and two lengths with shadow copies, the function
// word with run and stall bits, and the published result status.
// Assumes one register write per cycle; the datapath is external.
module bignum_op_ctl
    import bn_ctl_pkg::*;
#(
    parameter int PTR_W = 11,
    parameter int LEN_W = 9,
    parameter int SHF_W = 5,
    parameter int CMP_W = 3,
    parameter int MSW_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [WDATA_W-1:0] wr_data,
    input  logic               dp_done,
    input  logic [CMP_W-1:0]   dp_cmp,
    input  logic [MSW_W-1:0]   dp_msw,
    input  logic [MSW_W-1:0]   dp_divmsw,
    output logic [PTR_W-1:0]   ptr_a,
    output logic [PTR_W-1:0]   ptr_b,
    output logic [PTR_W-1:0]   ptr_c,
    output logic [PTR_W-1:0]   ptr_d,
    output logic [LEN_W-1:0]   len_a,
    output logic [LEN_W-1:0]   len_b,
    output logic [SHF_W-1:0]   shift_cnt,
    output logic [OPS_W-1:0]   op_sel,
    output logic               run,
    output logic               stall_res,
    output logic               op_start,
    output logic [CMP_W-1:0]   cmp_res,
    output logic [MSW_W-1:0]   msw_res,
    output logic [MSW_W-1:0]   divmsw_res,
    output logic               irq
);
    localparam int N_PTR = 4;
    localparam int N_LEN = 2;

    logic [PTR_W-1:0] ptr_v [N_PTR];
    logic [LEN_W-1:0] len_v [N_LEN];
    logic             hold_en, pub_direct, pub_release, commit;

    assign commit = pub_direct || pub_release;

    // Pointer bank: select codes 0..3, bit 0 forced low.
    for (genvar i = 0; i < N_PTR; i++) begin : g_ptr
        bn_shadow_reg #(.W(PTR_W), .ALIGN0(1'b1)) u_ptr (
            .clk(clk), .rst_n(rst_n),
            .wr(wr_en && (wr_sel == SEL_W'(int'(SEL_PTR_A) + i))),
            .wdata(wr_data[PTR_W-1:0]), .busy(run), .commit(commit),
            .value(ptr_v[i])
        );
    end

    // Length bank: select codes 4..5.
    for (genvar i = 0; i < N_LEN; i++) begin : g_len
        bn_shadow_reg #(.W(LEN_W), .ALIGN0(1'b0)) u_len (
            .clk(clk), .rst_n(rst_n),
            .wr(wr_en && (wr_sel == SEL_W'(int'(SEL_LEN_A) + i))),
            .wdata(wr_data[LEN_W-1:0]), .busy(run), .commit(commit),
            .value(len_v[i])
        );
    end

    bn_func_ctrl #(.SHF_W(SHF_W)) u_func (
        .clk(clk), .rst_n(rst_n),
        .wr_func(wr_en && (wr_sel == SEL_FUNC)),
        .wr_shift(wr_en && (wr_sel == SEL_SHIFT)),
        .wr_data(wr_data), .dp_done(dp_done),
        .run(run), .stall(stall_res), .op_sel(op_sel), .shift_cnt(shift_cnt),
        .op_start(op_start), .hold_en(hold_en),
        .pub_direct(pub_direct), .pub_release(pub_release)
    );

    bn_result_hold #(.CMP_W(CMP_W), .MSW_W(MSW_W)) u_res (
        .clk(clk), .rst_n(rst_n),
        .hold_en(hold_en), .pub_direct(pub_direct), .pub_release(pub_release),
        .dp_cmp(dp_cmp), .dp_msw(dp_msw), .dp_divmsw(dp_divmsw),
        .cmp_res(cmp_res), .msw_res(msw_res), .divmsw_res(divmsw_res)
    );

    assign ptr_a = ptr_v[0];
    assign ptr_b = ptr_v[1];
    assign ptr_c = ptr_v[2];
    assign ptr_d = ptr_v[3];
    assign len_a = len_v[0];
    assign len_b = len_v[1];
    assign irq   = !run;
endmodule

// File: rtl/bignum_op_ctl_chk.sv
// Protocol checker for bignum_op_ctl, attached through bind.
// Observes top-level ports only.
module bignum_op_ctl_chk #(
    parameter int PTR_W = 11,
    parameter int LEN_W = 9,
    parameter int SHF_W = 5,
    parameter int CMP_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [2:0]         wr_sel,
    input logic [31:0]        wr_data,
    input logic [PTR_W-1:0]   ptr_a,
    input logic [PTR_W-1:0]   ptr_b,
    input logic [LEN_W-1:0]   len_a,
    input logic [LEN_W-1:0]   len_b,
    input logic [SHF_W-1:0]   shift_cnt,
    input logic [11:0]        op_sel,
    input logic               run,
    input logic               stall_res,
    input logic               op_start,
    input logic [CMP_W-1:0]   cmp_res
);
    AST_PTR_ALIGNED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd0 && !run) |=> (ptr_a == {$past(wr_data[PTR_W-1:1]), 1'b0})); // R2
    AST_OPERANDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> ($stable(ptr_a) && $stable(ptr_b) && $stable(len_a) && $stable(len_b))); // R4
    AST_START_WITH_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> op_start); // R5
    AST_START_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start); // R5
    AST_START_SINGLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> ($countones({op_sel[11:4], op_sel[1:0]}) == 1)); // R6
    AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> ($stable(shift_cnt) && $stable(op_sel))); // R7
    AST_RESULT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp_res) |-> $fell(run)); // R8
    AST_STALL_HOLDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && stall_res) |=> run); // R9
endmodule

bind bignum_op_ctl bignum_op_ctl_chk #(
    .PTR_W(PTR_W), .LEN_W(LEN_W), .SHF_W(SHF_W), .CMP_W(CMP_W)
) u_chk (.*);

// File: tb/bignum_op_ctl_test.sv
// Self-checking bench for bignum_op_ctl: sweeps pointers, lengths and op patterns.
module bignum_op_ctl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [31:0] wr_data;
    logic        dp_done;
    logic [2:0]  dp_cmp;
    logic [15:0] dp_msw, dp_divmsw;
    logic [10:0] ptr_a, ptr_b, ptr_c, ptr_d;
    logic [8:0]  len_a, len_b;
    logic [4:0]  shift_cnt;
    logic [11:0] op_sel;
    logic        run, stall_res, op_start, irq;
    logic [2:0]  cmp_res;
    logic [15:0] msw_res, divmsw_res;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bignum_op_ctl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .dp_done(dp_done), .dp_cmp(dp_cmp), .dp_msw(dp_msw), .dp_divmsw(dp_divmsw),
        .ptr_a(ptr_a), .ptr_b(ptr_b), .ptr_c(ptr_c), .ptr_d(ptr_d),
        .len_a(len_a), .len_b(len_b), .shift_cnt(shift_cnt), .op_sel(op_sel),
        .run(run), .stall_res(stall_res), .op_start(op_start),
        .cmp_res(cmp_res), .msw_res(msw_res), .divmsw_res(divmsw_res), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // One-cycle register write; returns at the falling edge after the write edge.
    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One-cycle datapath completion pulse.
    task automatic done(input logic [2:0] c, input logic [15:0] m, input logic [15:0] dv);
        @(negedge clk);
        dp_done = 1'b1; dp_cmp = c; dp_msw = m; dp_divmsw = dv;
        @(negedge clk);
        dp_done = 1'b0;
    endtask

    function automatic logic [10:0] ptr_of(input int i);
        case (i)
            0: return ptr_a;
            1: return ptr_b;
            2: return ptr_c;
            default: return ptr_d;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [10:0] pb_keep;
        logic [2:0]  ecmp;
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        dp_done = 1'b0; dp_cmp = '0; dp_msw = '0; dp_divmsw = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 run", run, 0);
        chk("R1 irq", irq, 1);
        chk("R1 op_start", op_start, 0);
        chk("R1 stall", stall_res, 0);
        chk("R1 ptrs", {ptr_a, ptr_b, ptr_c, ptr_d}, 0);
        chk("R1 lens", {len_a, len_b, shift_cnt}, 0);
        chk("R1 op_sel", op_sel, 0);
        chk("R1 results", {cmp_res, msw_res, divmsw_res}, 0);
        rst_n = 1'b1;

        // R2 R3 pointer sweep, bit 0 cleared
        for (int v = 0; v < 2048; v++) begin
            wr(3'(v % 4), 32'(v) | 32'hFFFF_F800);
            chk("R2 ptr align", ptr_of(v % 4), 11'(v) & 11'h7FE);
        end
        // R2 R3 length and shift sweep
        for (int v = 0; v < 512; v++) begin
            wr(3'd4, 32'(v));
            chk("R3 len_a", len_a, v);
            wr(3'd5, 32'(511 - v));
            chk("R3 len_b", len_b, 511 - v);
        end
        for (int v = 0; v < 32; v++) begin
            wr(3'd6, 32'(v));
            chk("R3 shift", shift_cnt, v);
        end

        // R5 R6 sweep of all function-bit patterns with the run bit set
        for (int v = 0; v < 4096; v++) begin
            logic [11:0] f;
            logic        ok;
            f  = 12'(v);
            ok = ($countones({f[11:4], f[1:0]}) == 1);
            wr(3'd7, 32'h0000_8000 | 32'(v));
            chk(ok ? "R5 start run" : "R6 reject run", run, ok);
            chk(ok ? "R5 start pulse" : "R6 reject pulse", op_start, ok);
            chk("R5 op_sel load", op_sel, f);
            if (ok) begin
                @(negedge clk);
                chk("R5 pulse width", op_start, 0);
                done(3'b001, 16'h0001, 16'h0002);
                chk("R8 run clear", run, 0);
                chk("R8 irq", irq, 1);
            end
        end

        // R4 R7 shadow copy and frozen control during a run
        wr(3'd0, 32'h100);
        wr(3'd4, 32'd5);
        wr(3'd6, 32'd3);
        pb_keep = ptr_b;
        wr(3'd7, 32'h0000_8010);
        chk("R5 add start", run, 1);
        wr(3'd0, 32'h2FF);
        wr(3'd4, 32'd7);
        wr(3'd6, 32'd9);
        wr(3'd7, 32'h0000_0001);
        chk("R4 ptr_a frozen", ptr_a, 11'h100);
        chk("R4 len_a frozen", len_a, 5);
        chk("R7 shift ignored", shift_cnt, 3);
        chk("R7 op_sel ignored", op_sel, 12'h010);
        done(3'b010, 16'h0033, 16'h0044);
        chk("R8 msw", msw_res, 16'h0033);
        chk("R8 divmsw", divmsw_res, 16'h0044);
        chk("R4 ptr_a committed", ptr_a, 11'h2FE);
        chk("R4 len_a committed", len_a, 7);
        chk("R4 ptr_b kept", ptr_b, pb_keep);
        chk("R7 shift after run", shift_cnt, 3);

        // R12 done while idle
        done(3'b100, 16'h7777, 16'h6666);
        chk("R12 idle done cmp", cmp_res, 3'b010);
        chk("R12 idle done msw", msw_res, 16'h0033);
        chk("R12 idle run", run, 0);

        // R9 R11 stalled result
        wr(3'd7, 32'h0100_8400);
        chk("R9 stall set", stall_res, 1);
        chk("R9 run", run, 1);
        done(3'b100, 16'h0012, 16'h8000);
        chk("R9 run held", run, 1);
        chk("R9 irq held", irq, 0);
        chk("R9 cmp held", cmp_res, 3'b010);
        chk("R9 msw held", msw_res, 16'h0033);
        wr(3'd7, 32'h0100_8001);
        chk("R11 op_sel kept", op_sel, 12'h400);
        wr(3'd7, 32'h0000_8010);
        chk("R9 stall cleared", stall_res, 0);
        chk("R9 run before release", run, 1);
        @(negedge clk);
        chk("R9 run released", run, 0);
        chk("R9 cmp published", cmp_res, 3'b100);
        chk("R9 msw published", msw_res, 16'h0012);
        chk("R9 divmsw published", divmsw_res, 16'h8000);
        chk("R11 no start", op_start, 0);
        chk("R11 op_sel after", op_sel, 12'h400);

        // R10 compare encoding across operand pairs
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                ecmp = {a > b, a < b, a == b};
                wr(3'd7, 32'h0000_8400);
                done(ecmp, 16'(a), 16'(b));
                chk("R10 cmp encoding", cmp_res, ecmp);
                chk("R8 run clear cmp", run, 0);
            end
        end

        summary();
        $finish;
    end
endmodule